// File: doc/BRIEF.md
# TDM Slot-Masked Serial Receiver

This block receives one serial data line in time-division-multiplexed form. A one-cycle bit strobe marks each valid bit. A frame sync, sampled with the first bit of a frame, splits the stream into numbered slots of `WORD_BITS` bits each. For every slot, a 32-bit enable mask decides whether the finished word is handed to the host. An enabled slot loads the receive data register and raises the receive-full flag, which also serves as the interrupt request. A disabled slot still shifts its bits, but it leaves the data register and both status flags untouched.

The host writes the mask through two 24-bit registers. Each register carries 16 mask bits. Host writes land in a shadow copy, and the receiver copies that shadow into its working mask only at the start of a frame. A frame already in progress therefore keeps its old setting. The number of slots per frame (1 to 32) is handled the same way.

A state machine tracks the frame. It has three states:
- **HUNT**: waits after reset for the first frame sync.
- **SLOT**: collects bits.
- **TAIL**: ignores bits after the last programmed slot.

It has these transitions:
- **start** (HUNT→SLOT on a frame sync).
- **advance** (SLOT→SLOT at the end of a word that is not the last one).
- **resync** (SLOT→SLOT on a frame sync during a slot).
- **finish** (SLOT→TAIL at the end of the last slot).
- **restart** (TAIL→SLOT on a frame sync).

Top module: `tdmrx_slot_rx`

## Requirements
- R1: A bit strobe with frame sync high starts a frame at slot 0, and that bit is the first (most significant) bit of slot 0. Each following `WORD_BITS` strobes form the next slot. Once the programmed number of slots is complete, further strobes deliver nothing until the next frame sync. A frame sync in the middle of a slot drops the partial word and restarts at slot 0.
- R2: When a slot finishes and its mask bit N is clear, the data register, the full flag and the overrun flag all keep their values.
- R3: When a slot finishes and its mask bit N is set, the completed word is loaded into the data register (host address 0, bits WORD_BITS-1:0, upper bits zero) and the full flag is set.
- R4: When an enabled slot finishes while the full flag is already set, the overrun flag is set and the new word overwrites the data register.
- R5: A mask write affects only frames that start after it. A write in the same cycle as a frame sync takes effect from the frame after the one that sync starts.
- R6: Mask bits 0..15 are held at host address 2, bits 15:0. Mask bits 16..31 are held at address 3, bits 15:0. A read of either address returns the last written value at once. Bits 23:16 of both addresses read as zero.
- R7: After reset:
  - all mask bits are 1;
  - the slot-count field reads 31;
  - the full and overrun flags are 0;
  - the data register reads 0.
- R8: A host read of address 0 clears the full flag. If an enabled slot finishes in the same cycle, the flag stays set.
- R9: Address 1 reports the full flag in bit 0 and the overrun flag in bit 1. Writing 1 to bit 1 clears the overrun flag. Writing 0 to bit 1 leaves it unchanged.
- R10: Address 4, bits 4:0, hold the slot count minus one. The receiver takes this value at frame start, like the mask.
- R11: The `full_irq` output always equals the full flag, so a disabled slot never raises an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_en | input | 1 | One-cycle strobe marking a valid serial bit |
| fsync | input | 1 | Frame sync, sampled with `bit_en` |
| sdata | input | 1 | Serial data bit |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects at address 0) |
| host_wdata | input | 24 | Write data |
| host_rdata | output | 24 | Read data (combinational) |
| full_irq | output | 1 | Receive-full flag / interrupt request |
| ovr_flag | output | 1 | Overrun flag |

## Verification
The hardest case to reach is a mask write that lands in exactly the same clock cycle as a frame sync. The bench reaches it with a bit task that can issue a host write or read in the same cycle as its strobe. This same path also places a data read in the cycle in which an enabled slot finishes. Random frames cover the rest: random masks and slot counts, mask rewrites in the middle of a frame, and reads left out at random so that overruns build up. Directed frames cover a single slot, all 32 slots, trailing bits after the last slot, and an aborted slot.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;
    localparam int MAX_SLOTS = 32;
    localparam int SLOT_W    = $clog2(MAX_SLOTS);
    localparam int HALF_W    = MAX_SLOTS / 2;
    localparam int REG_W     = 24;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_MLO  = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_MHI  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd4;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SLOT = 2'd1,
        ST_TAIL = 2'd2
    } rx_state_t;
endpackage

// File: rtl/tdmrx_mask_regs.sv
module tdmrx_mask_regs
    import tdmrx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 frame_start,
    output logic [MAX_SLOTS-1:0] shadow_rb,
    output logic [MAX_SLOTS-1:0] act_mask,
    output logic [SLOT_W-1:0]    cfg_rb,
    output logic [SLOT_W-1:0]    act_last
);
    localparam int NHALF = MAX_SLOTS / HALF_W;

    // Each half: host-written shadow, copied to the working copy at frame start
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        localparam logic [ADDR_W-1:0] MY_ADDR = (h == 0) ? ADDR_MLO : ADDR_MHI;
        logic [HALF_W-1:0] shadow_q;
        logic [HALF_W-1:0] work_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                shadow_q <= '1;
            else if (wr && addr == MY_ADDR)
                shadow_q <= wdata[HALF_W-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                work_q <= '1;
            else if (frame_start)
                work_q <= shadow_q;
        end

        assign shadow_rb[h*HALF_W +: HALF_W] = shadow_q;
        assign act_mask[h*HALF_W +: HALF_W]  = work_q;
    end

    logic [SLOT_W-1:0] cfg_q;
    logic [SLOT_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= '1;
        else if (wr && addr == ADDR_CFG)
            cfg_q <= wdata[SLOT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_q <= '1;
        else if (frame_start)
            last_q <= cfg_q;
    end

    assign cfg_rb   = cfg_q;
    assign act_last = last_q;
endmodule

// File: rtl/tdmrx_slot_fsm.sv
module tdmrx_slot_fsm
    import tdmrx_pkg::*;
#(
    parameter int WORD_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fsync,
    input  logic [SLOT_W-1:0] act_last,
    output logic              frame_start,
    output logic              shift_en,
    output logic              word_done,
    output logic [SLOT_W-1:0] slot_idx
);
    localparam int CNT_W = (WORD_BITS > 2) ? $clog2(WORD_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

    rx_state_t         state_q, state_nx;
    logic [CNT_W-1:0]  bit_q, bit_nx;
    logic [SLOT_W-1:0] slot_q, slot_nx;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            bit_q   <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_nx;
            bit_q   <= bit_nx;
            slot_q  <= slot_nx;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx    = state_q;
        bit_nx      = bit_q;
        slot_nx     = slot_q;
        frame_start = bit_en && fsync;
        shift_en    = 1'b0;
        word_done   = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (frame_start) begin            // start
                    state_nx = ST_SLOT;
                    shift_en = 1'b1;
                    bit_nx   = CNT_W'(1);
                    slot_nx  = '0;
                end
            end
            ST_SLOT: begin
                if (frame_start) begin            // resync
                    shift_en = 1'b1;
                    bit_nx   = CNT_W'(1);
                    slot_nx  = '0;
                end else if (bit_en) begin
                    shift_en = 1'b1;
                    if (bit_q == LAST_BIT) begin
                        word_done = 1'b1;
                        bit_nx    = '0;
                        if (slot_q == act_last)
                            state_nx = ST_TAIL;   // finish
                        else
                            slot_nx = slot_q + 1'b1;  // advance
                    end else begin
                        bit_nx = bit_q + 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                if (frame_start) begin            // restart
                    state_nx = ST_SLOT;
                    shift_en = 1'b1;
                    bit_nx   = CNT_W'(1);
                    slot_nx  = '0;
                end
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    assign slot_idx = slot_q;
endmodule

// File: rtl/tdmrx_shifter.sv
module tdmrx_shifter #(
    parameter int WORD_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 sdata,
    output logic [WORD_BITS-1:0] word_next
);
    logic [WORD_BITS-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else if (shift_en)
            sh_q <= word_next;
    end

    // Word as it stands once the present bit is included, MSB first
    assign word_next = {sh_q[WORD_BITS-2:0], sdata};
endmodule

// File: rtl/tdmrx_slot_rx.sv
module tdmrx_slot_rx
    import tdmrx_pkg::*;
#(
    parameter int WORD_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fsync,
    input  logic              sdata,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [23:0]       host_wdata,
    output logic [23:0]       host_rdata,
    output logic              full_irq,
    output logic              ovr_flag
);
    logic                 frame_start;
    logic                 shift_en;
    logic                 word_done;
    logic [SLOT_W-1:0]    slot_idx;
    logic [SLOT_W-1:0]    act_last;
    logic [SLOT_W-1:0]    cfg_rb;
    logic [MAX_SLOTS-1:0] act_mask;
    logic [MAX_SLOTS-1:0] shadow_rb;
    logic [WORD_BITS-1:0] word_next;
    logic [WORD_BITS-1:0] data_q;
    logic                 full_q;
    logic                 ovr_q;
    logic                 slot_en;
    logic                 deliver;
    logic                 rd_data;
    logic                 ovr_clr;

    tdmrx_mask_regs i_masks (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (host_wr),
        .addr        (host_addr),
        .wdata       (host_wdata),
        .frame_start (frame_start),
        .shadow_rb   (shadow_rb),
        .act_mask    (act_mask),
        .cfg_rb      (cfg_rb),
        .act_last    (act_last)
    );

    tdmrx_slot_fsm #(.WORD_BITS(WORD_BITS)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .fsync       (fsync),
        .act_last    (act_last),
        .frame_start (frame_start),
        .shift_en    (shift_en),
        .word_done   (word_done),
        .slot_idx    (slot_idx)
    );

    tdmrx_shifter #(.WORD_BITS(WORD_BITS)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .sdata     (sdata),
        .word_next (word_next)
    );

    assign slot_en = act_mask[slot_idx];
    assign deliver = word_done && slot_en;
    assign rd_data = host_rd && host_addr == ADDR_DATA;
    assign ovr_clr = host_wr && host_addr == ADDR_STAT && host_wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (deliver)
            data_q <= word_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            full_q <= 1'b0;
        else if (deliver)
            full_q <= 1'b1;
        else if (rd_data)
            full_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovr_q <= 1'b0;
        else if (deliver && full_q)
            ovr_q <= 1'b1;
        else if (ovr_clr)
            ovr_q <= 1'b0;
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            ADDR_DATA: host_rdata = REG_W'(data_q);
            ADDR_STAT: host_rdata = {22'd0, ovr_q, full_q};
            ADDR_MLO:  host_rdata = {8'd0, shadow_rb[HALF_W-1:0]};
            ADDR_MHI:  host_rdata = {8'd0, shadow_rb[MAX_SLOTS-1:HALF_W]};
            ADDR_CFG:  host_rdata = REG_W'(cfg_rb);
            default:   host_rdata = '0;
        endcase
    end

    assign full_irq = full_q;
    assign ovr_flag = ovr_q;
endmodule

// File: rtl/tdmrx_checker.sv
module tdmrx_checker
    import tdmrx_pkg::*;
#(
    parameter int WORD_BITS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           host_addr,
    input logic                 host_rd,
    input logic                 host_wr,
    input logic [23:0]          host_wdata,
    input logic [23:0]          host_rdata,
    input logic                 full_irq,
    input logic                 ovr_flag,
    input logic                 frame_start,
    input logic                 word_done,
    input logic                 slot_en,
    input logic [MAX_SLOTS-1:0] act_mask,
    input logic [WORD_BITS-1:0] data_q
);
    // R2: disabled slot leaves data and overrun untouched
    a_r2_masked_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !slot_en) |=> $stable(data_q));
    a_r2_masked_no_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !slot_en) |=> (ovr_flag <= $past(ovr_flag)));
    // R3 / R11: full rises only after an enabled slot completes
    a_r3_full_from_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_irq) |-> $past(word_done && slot_en));
    // R4: overrun rises only when full was already set
    a_r4_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(word_done && slot_en && full_irq));
    // R5: working mask changes only at frame start
    a_r5_mask_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(act_mask));
    // R6: reserved bits of the mask registers read zero
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == ADDR_MLO || host_addr == ADDR_MHI) |-> host_rdata[23:16] == 8'd0);
    // R8: data read clears full unless a delivery collides
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_DATA && !(word_done && slot_en)) |=> !full_irq);
    // R9: write-one clears overrun when no overrun is being raised
    a_r9_w1c_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_STAT && host_wdata[1] && !(word_done && slot_en))
        |=> !ovr_flag);
endmodule

bind tdmrx_slot_rx tdmrx_checker #(.WORD_BITS(WORD_BITS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .full_irq    (full_irq),
    .ovr_flag    (ovr_flag),
    .frame_start (frame_start),
    .word_done   (word_done),
    .slot_en     (slot_en),
    .act_mask    (act_mask),
    .data_q      (data_q)
);

// File: tb/test_tdmrx_slot_rx.sv
module test_tdmrx_slot_rx;
    localparam int WB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        fsync = 1'b0;
    logic        sdata = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [23:0] host_wdata = '0;
    logic [23:0] host_rdata;
    logic        full_irq;
    logic        ovr_flag;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] m_shadow = '1;
    logic [31:0] m_act = '1;
    int          m_cfg = 31;
    int          m_last = 31;
    logic [23:0] m_data = '0;
    bit          m_full = 1'b0;
    bit          m_ovr = 1'b0;

    always #2 clk = ~clk;

    tdmrx_slot_rx #(.WORD_BITS(WB)) i_tdmrx_slot_rx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .sdata(sdata),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .full_irq(full_irq), .ovr_flag(ovr_flag)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one serial bit, optionally with a host access in the same cycle
    task automatic bit_tick(input logic b, input logic fs, input bit wr_en,
                            input logic [2:0] a, input logic [23:0] d,
                            input bit rd_en, output logic [23:0] rv);
        @(negedge clk);
        sdata = b; fsync = fs; bit_en = 1'b1;
        host_wr = wr_en; host_rd = rd_en; host_addr = a; host_wdata = d;
        #1 rv = host_rdata;
        @(negedge clk);
        bit_en = 1'b0; fsync = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic host_write(input logic [2:0] a, input logic [23:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [23:0] v);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    function automatic logic [31:0] next_mask_model(input logic [31:0] old, input bit hi,
                                                    input logic [15:0] v);
        logic [31:0] r = old;
        if (hi) r[31:16] = v; else r[15:0] = v;
        return r;
    endfunction

    task automatic set_mask(input logic [31:0] m);
        logic [23:0] v;
        host_write(3'd2, {8'hA5, m[15:0]});
        host_write(3'd3, {8'h5A, m[31:16]});
        m_shadow = m;
        host_read(3'd2, v); check("R6 mask low readback", v, {8'd0, m[15:0]});
        host_read(3'd3, v); check("R6 mask high readback", v, {8'd0, m[31:16]});
    endtask

    // A full frame. sync_wr: mask-low write in the fsync cycle.
    // mid_slot: rewrite mask before that slot (-1 none). rd_pct: chance of reading after a slot.
    // collide_slot: read data in the last-bit cycle of that slot. tail: trailing bits.
    task automatic run_frame(input bit sync_wr, input logic [15:0] sync_val,
                             input int mid_slot, input int rd_pct,
                             input int collide_slot, input int tail);
        logic [23:0] rv;
        logic [23:0] word;
        m_act  = m_shadow;
        m_last = m_cfg;
        for (int s = 0; s <= m_last; s++) begin
            if (s == mid_slot && s != 0)
                set_mask($urandom());
            word = 24'($urandom() & ((1 << WB) - 1));
            for (int b = WB - 1; b >= 0; b--) begin
                if (s == 0 && b == WB - 1) begin
                    bit_tick(word[b], 1'b1, sync_wr, 3'd2, {8'd0, sync_val}, 1'b0, rv);
                    if (sync_wr) m_shadow = next_mask_model(m_shadow, 1'b0, sync_val);
                end else if (b == 0 && s == collide_slot) begin
                    bit_tick(word[b], 1'b0, 1'b0, 3'd0, 24'd0, 1'b1, rv);
                    check("R8 collide read old data", rv, m_data);
                    if (!m_act[s]) m_full = 1'b0;
                end else begin
                    bit_tick(word[b], 1'b0, 1'b0, 3'd0, 24'd0, 1'b0, rv);
                end
            end
            if (m_act[s]) begin
                if (m_full) m_ovr = 1'b1;
                m_full = 1'b1;
                m_data = word;
            end
            check(m_act[s] ? "R3 full after enabled slot" : "R2 full after masked slot",
                  32'(full_irq), 32'(m_full));
            check(m_act[s] ? "R4 overrun after enabled slot" : "R2 overrun after masked slot",
                  32'(ovr_flag), 32'(m_ovr));
            check("R11 irq equals full", 32'(full_irq), 32'(m_full));
            if (int'($urandom_range(99)) < rd_pct) begin
                host_read(3'd0, rv);
                check("R3 data register", rv, m_data);
                m_full = 1'b0;
                check("R8 read clears full", 32'(full_irq), 32'(m_full));
            end
            if ($urandom_range(7) == 0) begin
                host_write(3'd1, 24'h000002);
                m_ovr = 1'b0;
                host_read(3'd1, rv);
                check("R9 status after overrun clear", rv, {22'd0, m_ovr, m_full});
            end
        end
        for (int t = 0; t < tail; t++)
            bit_tick(1'($urandom()), 1'b0, 1'b0, 3'd0, 24'd0, 1'b0, rv);
        host_read(3'd1, rv);
        check("R1 no delivery after last slot", rv, {22'd0, m_ovr, m_full});
    endtask

    task automatic set_cfg(input int n);
        logic [23:0] v;
        host_write(3'd4, 24'(n));
        m_cfg = n;
        host_read(3'd4, v);
        check("R10 slot count readback", v, 24'(n));
    endtask

    initial begin
        logic [23:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state
        host_read(3'd2, v); check("R7 mask low reset", v, 24'h00FFFF);
        host_read(3'd3, v); check("R7 mask high reset", v, 24'h00FFFF);
        host_read(3'd4, v); check("R7 slot count reset", v, 24'd31);
        host_read(3'd1, v); check("R7 status reset", v, 24'd0);
        host_read(3'd0, v); check("R7 data reset", v, 24'd0);
        check("R7 irq reset", 32'(full_irq), 32'd0);

        // R6 reserved bits
        host_write(3'd2, 24'hABCDEF);
        host_read(3'd2, v); check("R6 reserved bits read zero", v, 24'h00CDEF);
        set_mask(32'hFFFF_FFFF);

        // R9: writing zero to bit 1 does not clear overrun; build one first
        set_cfg(3);
        set_mask(32'h0000_0005);
        run_frame(1'b0, 16'h0, -1, 0, -1, 6);       // slot 2 overruns slot 0 (R4)
        host_write(3'd1, 24'h000001);
        host_read(3'd1, v); check("R9 write zero keeps overrun", v, {22'd0, m_ovr, m_full});
        host_write(3'd1, 24'h000002);
        m_ovr = 1'b0;
        host_read(3'd1, v); check("R9 write one clears overrun", v, {22'd0, m_ovr, m_full});

        // R5: mask write in the fsync cycle applies only to the following frame
        set_mask(32'hFFFF_FFFF);
        run_frame(1'b1, 16'h0000, -1, 100, -1, 3);  // this frame still all enabled
        run_frame(1'b0, 16'h0, -1, 100, -1, 3);     // slots 0..3 now disabled

        // R8 collision: read in the completing cycle of an enabled slot
        set_mask(32'hFFFF_FFFF);
        run_frame(1'b0, 16'h0, -1, 0, 2, 2);

        // R1 resync: partial slot aborted by a new frame sync
        begin
            logic [23:0] rv;
            m_act = m_shadow; m_last = m_cfg;
            for (int b = 0; b < 7; b++)
                bit_tick(1'b1, b == 0, 1'b0, 3'd0, 24'd0, 1'b0, rv);
            host_read(3'd1, v); check("R1 partial slot not delivered", v, {22'd0, m_ovr, m_full});
            run_frame(1'b0, 16'h0, -1, 100, -1, 0);
        end

        // R10 / R1: single slot, then all 32 slots
        set_cfg(0);
        set_mask($urandom());
        run_frame(1'b0, 16'h0, -1, 50, -1, 20);
        set_cfg(31);
        run_frame(1'b0, 16'h0, 5, 60, -1, 4);

        // random frames
        for (int f = 0; f < 24; f++) begin
            set_cfg(int'($urandom_range(7)));
            set_mask($urandom());
            run_frame($urandom_range(3) == 0, 16'($urandom()),
                      int'($urandom_range(8)), int'($urandom_range(100)),
                      ($urandom_range(3) == 0) ? int'($urandom_range(7)) : -1,
                      int'($urandom_range(5)));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule